// File: doc/BRIEF.md
# Resolve Copy and Clear Pixel Unit

The unit sits in the pixel path of a surface copy/fill engine. Each accepted pixel carries its horizontal coordinate, the word read from the source surface, the word currently held in the destination and a flag saying whether its tile is marked as cleared. The unit produces the 32-bit word to write back. Depending on the programmed mode, it passes the source through unchanged, or replaces selected byte lanes with a programmed fill value while the other lanes keep the old destination contents.

There are two fill modes. The first uses one fill value. The second rotates through four fill values in vertical stripes four pixels wide. A 16-bit clear mask holds four 4-bit groups, one bit per byte lane. When tile status is enabled, a pixel whose tile is flagged as cleared is filled even while the unit is copying. The unit has a valid/ready handshake at each end and one register stage between them.

Top module: `rsv_clear_pipe`

## Requirements
- R1: During and right after synchronous reset `out_valid` is 0 and `in_ready` is 1.
- R2: In copy mode (`cfg_mode` = 0), when the pixel is not a cleared tile under tile status, the output equals `in_src` in full, whatever the mask holds.
- R3: In single-fill mode (`cfg_mode` = 1), byte lane i (bits 8i+7:8i) takes lane i of fill value 0 when `cfg_mask[i]` is 1. Otherwise it keeps lane i of `in_dst`. `in_src` has no effect.
- R4: In striped-fill mode (`cfg_mode` = 2), k = `in_x[3:2]` selects fill value k (`cfg_fill[32k+31:32k]`) and mask group k (`cfg_mask[4k+3:4k]`). Each lane then takes the fill value or the destination as in R3. `in_src` has no effect.
- R5: In single-fill mode, mask bits 15:4 have no effect on the output.
- R6: In copy mode with `ts_en` = 1 and `in_tile_clr` = 1, the output is fill value 0 merged with `in_dst` under `cfg_mask[3:0]`, and `in_src` is not used.
- R7: With `ts_en` = 0, `in_tile_clr` has no effect, and copy mode passes `in_src`.
- R8: The reserved mode value 3 behaves as copy mode.
- R9: A pixel accepted on a clock edge (`in_valid` and `in_ready` high) appears on `out_valid`/`out_data` after that edge. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 copy, 1 single fill, 2 striped fill, 3 reserved (copy) |
| cfg_fill | input | 128 | Four fill values, value k in bits 32k+31:32k |
| cfg_mask | input | 16 | Four groups of four lane-enable bits |
| ts_en | input | 1 | Tile status enable |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Unit can accept a pixel |
| in_x | input | 16 | Pixel x coordinate |
| in_src | input | 32 | Source word |
| in_dst | input | 32 | Current destination word |
| in_tile_clr | input | 1 | Pixel's tile is marked cleared |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | 32 | Word to write |

## Verification
The source and destination words use byte values that differ from each other and from every lane of all four fill values. Each output lane therefore shows where it came from: the source, the destination or a particular fill value. Striped fill is driven at x = 0, 5, 8, 12 and 16 with a mask that enables a different lane in each group. This separates a wrong stripe index, a wrong mask group and a missing wrap. Copy mode is run with the cleared flag on and off, and with tile status on and off. This separates tile-status fills from plain copies. A stall test with `out_ready` low shows whether the output holds and whether a waiting pixel is lost.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    RSV_COPY      = 2'd0,
    RSV_FILL_ONE  = 2'd1,
    RSV_FILL_QUAD = 2'd2,
    RSV_RSVD      = 2'd3
  } rsv_mode_e;
endpackage

// File: rtl/rsv_fill_select.sv
module rsv_fill_select #(
  parameter int WORD_W     = 32,
  parameter int LANES      = 4,
  parameter int NFILL      = 4,
  parameter int X_W        = 16,
  parameter int STRIPE_LOG = 2,
  localparam int SEL_W     = $clog2(NFILL),
  localparam int MASK_W    = LANES * NFILL
) (
  input  logic [1:0]              mode,
  input  logic [NFILL*WORD_W-1:0] fill_vals,
  input  logic [MASK_W-1:0]       mask,
  input  logic [X_W-1:0]          x,
  input  logic                    ts_en,
  input  logic                    tile_clr,
  output logic [WORD_W-1:0]       fill_word,
  output logic [LANES-1:0]        lane_en,
  output logic                    use_fill
);
  import rsv_pkg::*;

  logic [SEL_W-1:0] k;

  always_comb begin
    if (mode == RSV_FILL_QUAD) k = x[STRIPE_LOG +: SEL_W];
    else                       k = '0;
    fill_word = fill_vals[k*WORD_W +: WORD_W];
    lane_en   = mask[k*LANES +: LANES];
    use_fill  = (mode == RSV_FILL_ONE) || (mode == RSV_FILL_QUAD) ||
                (ts_en && tile_clr);
  end
endmodule

// File: rtl/rsv_lane_merge.sv
module rsv_lane_merge #(
  parameter int WORD_W  = 32,
  parameter int LANE_W  = 8,
  localparam int LANES  = WORD_W / LANE_W
) (
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] fill_word,
  input  logic [LANES-1:0]  lane_en,
  input  logic              use_fill,
  output logic [WORD_W-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (!use_fill)       merged[i*LANE_W +: LANE_W] = src[i*LANE_W +: LANE_W];
      else if (lane_en[i]) merged[i*LANE_W +: LANE_W] = fill_word[i*LANE_W +: LANE_W];
      else                 merged[i*LANE_W +: LANE_W] = dst[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/rsv_clear_pipe.sv
module rsv_clear_pipe #(
  parameter int WORD_W     = 32,
  parameter int LANE_W     = 8,
  parameter int NFILL      = 4,
  parameter int X_W        = 16,
  parameter int STRIPE_LOG = 2,
  localparam int LANES     = WORD_W / LANE_W,
  localparam int MASK_W    = LANES * NFILL
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              cfg_mode,
  input  logic [NFILL*WORD_W-1:0] cfg_fill,
  input  logic [MASK_W-1:0]       cfg_mask,
  input  logic                    ts_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [X_W-1:0]          in_x,
  input  logic [WORD_W-1:0]       in_src,
  input  logic [WORD_W-1:0]       in_dst,
  input  logic                    in_tile_clr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_data
);
  logic [WORD_W-1:0] fill_word;
  logic [LANES-1:0]  lane_en;
  logic              use_fill;
  logic [WORD_W-1:0] merged;
  logic              take;

  rsv_fill_select #(
    .WORD_W(WORD_W), .LANES(LANES), .NFILL(NFILL),
    .X_W(X_W), .STRIPE_LOG(STRIPE_LOG)
  ) u_sel (
    .mode(cfg_mode), .fill_vals(cfg_fill), .mask(cfg_mask), .x(in_x),
    .ts_en(ts_en), .tile_clr(in_tile_clr),
    .fill_word(fill_word), .lane_en(lane_en), .use_fill(use_fill)
  );

  rsv_lane_merge #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_merge (
    .src(in_src), .dst(in_dst), .fill_word(fill_word),
    .lane_en(lane_en), .use_fill(use_fill), .merged(merged)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= merged;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsv_clear_chk.sv
module rsv_clear_chk #(
  parameter int WORD_W = 32,
  parameter int NFILL  = 4,
  parameter int MASK_W = 16,
  parameter int X_W    = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              cfg_mode,
  input logic [NFILL*WORD_W-1:0] cfg_fill,
  input logic [MASK_W-1:0]       cfg_mask,
  input logic                    ts_en,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [X_W-1:0]          in_x,
  input logic [WORD_W-1:0]       in_src,
  input logic [WORD_W-1:0]       in_dst,
  input logic                    in_tile_clr,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [WORD_W-1:0]       out_data
);
  import rsv_pkg::*;

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

  // R9
  a_r9_accept_emits: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R2
  a_r2_copy: assert property (@(posedge clk) disable iff (rst)
    (acc && cfg_mode == RSV_COPY && !(ts_en && in_tile_clr))
    |=> out_data == $past(in_src));

  // R3
  a_r3_fill_full: assert property (@(posedge clk) disable iff (rst)
    (acc && cfg_mode == RSV_FILL_ONE && cfg_mask[3:0] == 4'hF)
    |=> out_data == $past(cfg_fill[WORD_W-1:0]));

  // R5
  a_r5_group0_only: assert property (@(posedge clk) disable iff (rst)
    (acc && cfg_mode == RSV_FILL_ONE && cfg_mask[3:0] == 4'h0)
    |=> out_data == $past(in_dst));
endmodule

bind rsv_clear_pipe rsv_clear_chk #(
  .WORD_W(WORD_W), .NFILL(NFILL), .MASK_W(MASK_W), .X_W(X_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_fill(cfg_fill),
  .cfg_mask(cfg_mask), .ts_en(ts_en), .in_valid(in_valid),
  .in_ready(in_ready), .in_x(in_x), .in_src(in_src), .in_dst(in_dst),
  .in_tile_clr(in_tile_clr), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_rsv_clear_pipe.sv
`timescale 1ns/1ps
module sim_rsv_clear_pipe;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   cfg_mode = 2'd0;
  logic [127:0] cfg_fill;
  logic [15:0]  cfg_mask = 16'h0;
  logic         ts_en = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [15:0]  in_x = 16'h0;
  logic [31:0]  in_src = 32'h0;
  logic [31:0]  in_dst = 32'h0;
  logic         in_tile_clr = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] SRC = 32'h11223344;
  localparam logic [31:0] DST = 32'h55667788;

  always #5 clk = ~clk;

  rsv_clear_pipe u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_fill(cfg_fill),
    .cfg_mask(cfg_mask), .ts_en(ts_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_x(in_x), .in_src(in_src), .in_dst(in_dst),
    .in_tile_clr(in_tile_clr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Send one pixel; the result is registered at the next edge and read
  // at the following falling edge.
  task automatic px(string req, logic [1:0] m, logic [15:0] mk, logic ts,
                    logic clr, logic [15:0] x, logic [31:0] exp);
    @(negedge clk);
    cfg_mode = m; cfg_mask = mk; ts_en = ts; in_tile_clr = clr; in_x = x;
    in_src = SRC; in_dst = DST; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, out_data, exp);
  endtask

  task automatic t_reset;
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", {31'd0, in_ready}, 32'd1);
    @(negedge clk); rst = 1'b0;
    check("R1", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_copy;
    px("R2", 2'd0, 16'h0000, 1'b0, 1'b0, 16'd0, SRC);
    px("R2", 2'd0, 16'hFFFF, 1'b1, 1'b0, 16'd7, SRC);
  endtask

  task automatic t_fill_one;
    px("R3", 2'd1, 16'h000F, 1'b0, 1'b0, 16'd3, 32'hA0A1A2A3);
    px("R3", 2'd1, 16'h0005, 1'b0, 1'b0, 16'd9, 32'h55A177A3);
    px("R5", 2'd1, 16'hFFF0, 1'b0, 1'b0, 16'd4, DST);
  endtask

  task automatic t_fill_quad;
    px("R4", 2'd2, 16'h8421, 1'b0, 1'b0, 16'd0,  32'h556677A3);
    px("R4", 2'd2, 16'h8421, 1'b0, 1'b0, 16'd5,  32'h5566B288);
    px("R4", 2'd2, 16'h8421, 1'b0, 1'b0, 16'd8,  32'h55C17788);
    px("R4", 2'd2, 16'h8421, 1'b0, 1'b0, 16'd12, 32'hD0667788);
    px("R4", 2'd2, 16'h8421, 1'b0, 1'b0, 16'd16, 32'h556677A3);
  endtask

  task automatic t_tile_status;
    px("R6", 2'd0, 16'hFFF3, 1'b1, 1'b1, 16'd12, 32'h5566A2A3);
    px("R7", 2'd0, 16'hFFFF, 1'b0, 1'b1, 16'd12, SRC);
    px("R8", 2'd3, 16'hFFFF, 1'b0, 1'b0, 16'd12, SRC);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    cfg_mode = 2'd1; cfg_mask = 16'h000F; ts_en = 1'b0; in_x = 16'd0;
    in_src = SRC; in_dst = DST; in_valid = 1'b1;
    @(negedge clk);
    check("R9", {31'd0, out_valid}, 32'd1);
    check("R9", {31'd0, in_ready}, 32'd0);
    check("R9", out_data, 32'hA0A1A2A3);
    cfg_mode = 2'd0;  // second pixel waits: copy of SRC
    @(negedge clk);
    @(negedge clk);
    check("R9", out_data, 32'hA0A1A2A3);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", {31'd0, out_valid}, 32'd1);
    check("R9", out_data, SRC);
    @(negedge clk);
    check("R9", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    cfg_fill = {32'hD0D1D2D3, 32'hC0C1C2C3, 32'hB0B1B2B3, 32'hA0A1A2A3};
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_copy();
    t_fill_one();
    t_fill_quad();
    t_tile_status();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule